// File: doc/BRIEF.md
# Coin Credit Vend Controller

This block is a clocked Moore state machine for a vending mechanism with one coin slot. An external coin sensor gives it a one-cycle pulse for each nickel or dime. The block keeps a running credit of 0, 5, 10 or 15 cents. While the credit stands at the 15-cent item price, it raises a release output that drives the item dispenser.

Credit stops at the price and no change is given: any coin that would take the total past 15 cents leaves it at exactly 15. The full-credit state is a credit state like the others. It lasts one cycle when no coin arrives, and the credit then returns to zero. A coin that lands in that cycle is counted from zero, so the credit starts over at 5 or 10 cents. A nickel and a dime reported in the same cycle are treated as a fault of the sensor, and the credit does not change.

Top module: `vend_credit_fsm`

## Requirements
- R1: Reset is synchronous and active high. While it is sampled high at a rising edge, the credit is forced to zero, and `release_o` is low during reset and in the first cycle after reset is released.
- R2: `release_o` is high exactly when the credit is 15 cents. It is a registered (Moore) output, so changing the coin inputs between clock edges does not change it.
- R3: With no coin present, a credit of 0, 5 or 10 cents is held across the edge.
- R4: With no coin present, a credit of 15 cents becomes zero at the next rising edge, so a release lasts exactly one cycle.
- R5: Below full credit, a nickel (`coin_nickel`=1, `coin_dime`=0) adds 5 cents and a dime (`coin_dime`=1, `coin_nickel`=0) adds 10 cents at the next rising edge.
- R6: A coin that brings the total to 15 cents or more leaves the credit at exactly 15 cents. For example, 10 cents plus a dime gives 15 cents and no change.
- R7: At full credit, a nickel moves the credit to 5 cents and a dime moves it to 10 cents. The new coin is counted from zero.
- R8: When `coin_nickel` and `coin_dime` are both high in the same cycle, the credit stays as it is, including at full credit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| coin_nickel | input | 1 | One-cycle pulse: a 5-cent coin has been sensed |
| coin_dime | input | 1 | One-cycle pulse: a 10-cent coin has been sensed |
| release_o | output | 1 | High while the credit equals the item price |

## Verification
The cases that are hardest to reach from the ports are a coin landing in the one cycle of full credit, and a clash of both coin inputs while the credit is full. To get there, the stimulus first completes a purchase with each of the four coin orders that reach the price. In the following cycle, while `release_o` is high, it then applies a nickel, a dime or a clash. The bench compares every cycle against an integer credit model. It also changes the coin inputs between clock edges to show that `release_o` does not react to them.

// File: rtl/vend_pkg.sv
package vend_pkg;

  localparam int unsigned CREDIT_W    = 2;
  localparam int unsigned PRICE_UNITS = 3;  // price counted in 5-cent units

  typedef enum logic [CREDIT_W-1:0] {
    CR_ZERO = 2'b00,
    CR_FIVE = 2'b01,
    CR_TEN  = 2'b10,
    CR_FULL = 2'b11
  } credit_e;

  typedef enum logic [1:0] {
    COIN_NONE   = 2'b00,
    COIN_NICKEL = 2'b01,
    COIN_DIME   = 2'b10,
    COIN_CLASH  = 2'b11
  } coin_e;

  // Number of 5-cent units a coin adds to the credit.
  function automatic logic [CREDIT_W:0] coin_units(coin_e c);
    case (c)
      COIN_NICKEL: return (CREDIT_W+1)'(1);
      COIN_DIME:   return (CREDIT_W+1)'(2);
      default:     return '0;
    endcase
  endfunction

  // Credit after one edge. At full credit the count starts again from zero,
  // and the total is capped at the price.
  function automatic credit_e credit_advance(credit_e cur, coin_e c);
    logic [CREDIT_W:0] base;
    logic [CREDIT_W:0] sum;
    if (c == COIN_CLASH) return cur;
    base = (cur == CR_FULL) ? '0 : {1'b0, cur};
    sum  = base + coin_units(c);
    if (sum >= (CREDIT_W+1)'(PRICE_UNITS)) return CR_FULL;
    return credit_e'(sum[CREDIT_W-1:0]);
  endfunction

endpackage

// File: rtl/vend_coin_classify.sv
module vend_coin_classify
  import vend_pkg::*;
(
  input  logic  nickel_i,
  input  logic  dime_i,
  output coin_e coin_o,
  output logic  clash_o
);

  always_comb begin
    unique case ({dime_i, nickel_i})
      2'b01:   coin_o = COIN_NICKEL;
      2'b10:   coin_o = COIN_DIME;
      2'b11:   coin_o = COIN_CLASH;
      default: coin_o = COIN_NONE;
    endcase
  end

  assign clash_o = nickel_i & dime_i;

endmodule

// File: rtl/vend_credit_next.sv
module vend_credit_next
  import vend_pkg::*;
(
  input  credit_e cur_i,
  input  coin_e   coin_i,
  output credit_e nxt_o,
  output logic    saturate_o
);

  logic [CREDIT_W:0] raw_sum;

  assign raw_sum    = {1'b0, cur_i} + coin_units(coin_i);
  assign nxt_o      = credit_advance(cur_i, coin_i);
  assign saturate_o = (cur_i != CR_FULL) && (coin_i != COIN_CLASH) &&
                      (raw_sum > (CREDIT_W+1)'(PRICE_UNITS));

endmodule

// File: rtl/vend_credit_reg.sv
module vend_credit_reg
  import vend_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  credit_e nxt_i,
  output credit_e cur_o
);

  always_ff @(posedge clk) begin
    if (rst) cur_o <= CR_ZERO;
    else     cur_o <= nxt_i;
  end

  // R1: synchronous reset forces zero credit
  a_r1_reset_zero: assert property (@(posedge clk) rst |=> cur_o == CR_ZERO);

endmodule

// File: rtl/vend_credit_fsm.sv
module vend_credit_fsm
  import vend_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic coin_nickel,
  input  logic coin_dime,
  output logic release_o
);

  coin_e   coin_w;
  logic    clash_w;
  logic    saturate_w;
  credit_e credit_q;
  credit_e credit_d;

  vend_coin_classify u_classify (
    .nickel_i (coin_nickel),
    .dime_i   (coin_dime),
    .coin_o   (coin_w),
    .clash_o  (clash_w)
  );

  vend_credit_next u_next (
    .cur_i      (credit_q),
    .coin_i     (coin_w),
    .nxt_o      (credit_d),
    .saturate_o (saturate_w)
  );

  vend_credit_reg u_reg (
    .clk   (clk),
    .rst   (rst),
    .nxt_i (credit_d),
    .cur_o (credit_q)
  );

  assign release_o = (credit_q == CR_FULL);

  // R3: idle below full credit holds
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (coin_w == COIN_NONE && credit_q != CR_FULL) |=> $stable(credit_q));

  // R4: idle at full credit clears, release lasts one cycle
  a_r4_full_clears: assert property (@(posedge clk) disable iff (rst)
    (release_o && !coin_nickel && !coin_dime) |=> !release_o);

  // R5: nickel from zero lands on five
  a_r5_nickel_from_zero: assert property (@(posedge clk) disable iff (rst)
    (credit_q == CR_ZERO && coin_w == COIN_NICKEL) |=> credit_q == CR_FIVE);

  // R6: overshoot saturates at full credit
  a_r6_saturate: assert property (@(posedge clk) disable iff (rst)
    saturate_w |=> release_o);

  // R7: coin during release restarts count
  a_r7_dime_restart: assert property (@(posedge clk) disable iff (rst)
    (release_o && coin_w == COIN_DIME) |=> credit_q == CR_TEN);
  a_r7_nickel_restart: assert property (@(posedge clk) disable iff (rst)
    (release_o && coin_w == COIN_NICKEL) |=> credit_q == CR_FIVE);

  // R8: clashing inputs hold the credit
  a_r8_clash_hold: assert property (@(posedge clk) disable iff (rst)
    clash_w |=> $stable(credit_q));

endmodule

// File: tb/vend_credit_fsm_tb_top.sv
`timescale 1ns/1ps
module vend_credit_fsm_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic coin_nickel = 1'b0;
  logic coin_dime = 1'b0;
  logic release_o;

  int checks = 0;
  int errors = 0;
  int model_cents = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vend_credit_fsm dut_i (
    .clk         (clk),
    .rst         (rst),
    .coin_nickel (coin_nickel),
    .coin_dime   (coin_dime),
    .release_o   (release_o)
  );

  task automatic check(input logic expv, input string tag);
    checks++;
    if (release_o !== expv) begin
      errors++;
      $display("FAIL %s release_o actual=%b expected=%b (model credit %0d)",
               tag, release_o, expv, model_cents);
    end
  endtask

  function automatic int model_step(int c, bit n, bit d, bit r);
    int add;
    if (r) return 0;
    if (n && d) return c;
    add = n ? 5 : (d ? 10 : 0);
    if (c == 15) c = 0;
    else if (add == 0) return c;
    c = c + add;
    return (c > 15) ? 15 : c;
  endfunction

  // Drive after a falling edge, check Moore stability, step the model at the
  // rising edge, then compare at the next falling edge.
  task automatic cyc(input bit n, input bit d, input string tag);
    coin_nickel = n;
    coin_dime   = d;
    #1;
    check(model_cents == 15, "R2 moore");
    @(posedge clk);
    model_cents = model_step(model_cents, n, d, rst);
    @(negedge clk);
    check(model_cents == 15, tag);
  endtask

  initial begin
    @(negedge clk);
    cyc(0, 0, "R1 in reset");
    cyc(1, 0, "R1 coin in reset");
    cyc(0, 1, "R1 dime in reset");
    rst = 1'b0;
    cyc(0, 0, "R1 after reset");
    cyc(0, 0, "R3 hold zero");
    // three nickels
    cyc(1, 0, "R5 nickel");
    cyc(0, 0, "R3 hold five");
    cyc(1, 0, "R5 nickel");
    cyc(0, 0, "R3 hold ten");
    cyc(1, 0, "R6 nickel to full");
    cyc(0, 0, "R4 full clears");
    cyc(0, 0, "R4 stays zero");
    // nickel then dime
    cyc(1, 0, "R5 nickel");
    cyc(0, 1, "R6 dime to full");
    cyc(1, 0, "R7 nickel at full");
    cyc(0, 1, "R6 dime to full");
    cyc(0, 0, "R4 full clears");
    // dime then nickel
    cyc(0, 1, "R5 dime");
    cyc(1, 0, "R6 nickel to full");
    cyc(0, 1, "R7 dime at full");
    cyc(0, 1, "R6 ten plus dime saturates");
    cyc(1, 1, "R8 clash at full");
    cyc(0, 0, "R4 full clears");
    // two dimes
    cyc(0, 1, "R5 dime");
    cyc(1, 1, "R8 clash at ten");
    cyc(0, 1, "R6 dime saturates");
    cyc(0, 1, "R7 dime at full");
    cyc(1, 0, "R6 nickel to full");
    cyc(0, 0, "R4 full clears");
    cyc(1, 1, "R8 clash at zero");
    cyc(1, 0, "R5 nickel");
    cyc(1, 1, "R8 clash at five");
    cyc(0, 0, "R3 hold five");
    // reset from nonzero credit
    rst = 1'b1;
    cyc(0, 0, "R1 reset clears");
    rst = 1'b0;
    cyc(0, 0, "R1 after reset");
    for (int i = 0; i < 40; i++) begin
      cyc(((i % 3) == 0), ((i % 5) == 1), "R5 mixed stream");
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule